// File: doc/BRIEF.md
# DDR SDRAM command and bank tracker

This block follows the control side of a four-bank, x16 double-data-rate SDRAM one cycle at a time. On every rising clock edge it samples the command pins, the bank address, the address bus and clock enable. It decodes the command and keeps two things for each bank: an open flag and the row that is open. It also holds the mode register and the extended mode register, and it classifies the power state of the device.

A memory controller model or a protocol monitor places it beside the command bus. It can then check that a command stream is legal. Illegal attempts show up as a one-cycle error pulse, and the tracked bank state is left as it was. If clock enable drops while a read or write burst is still running, a separate violation pulse is raised. A simple busy flag covers the burst window. The block does not model the data path or any AC timing.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When `cs_n` is high at a clock edge, the command is treated as no operation. The bank state and mode registers do not change and no error is raised.
- R2: With `cs_n` low, `{ras_n,cas_n,we_n}` is decoded as follows: 111 NOP, 011 Activate, 101 Read, 100 Write, 010 Precharge, 001 Refresh, 000 Mode Set, 110 Burst Stop. An Activate sets `bank_open[ba]` and latches `addr` into `open_row[ba*ADDR_W +: ADDR_W]`.
- R3: An Activate to an open bank, or a Read or Write to an idle bank, sets `err_illegal` for one cycle after the edge. The bank state is left unchanged.
- R4: A Precharge with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes every bank, whatever `ba` holds.
- R5: A Read or Write holds `busy` high for BURST_CYC cycles after its edge. If `addr[10]` is set, the bank closes at the edge BURST_CYC cycles after the command. A Read or Write issued while such a close is still pending is illegal. A Burst Stop clears `busy` at once and completes any pending close on the same edge.
- R6: A Mode Set with all banks idle writes `addr` into `mode_reg` when `ba`=0 and into `ext_mode_reg` when `ba`=1. Any other `ba` value, or any open bank, raises `err_illegal` and nothing is written.
- R7: A Refresh with `cke` high while any bank is open raises `err_illegal`. A Refresh with all banks idle changes no state.
- R8: `cke` low at an edge in the active state (`pwr_state`=0), with no burst running, enters a power-down state. The state is precharge power-down (1) when all banks are idle and active power-down (2) when any bank is open. The command at that edge is ignored.
- R9: A Refresh with `cke` low and all banks idle enters self refresh (3). If a bank is open, the same command raises `err_illegal` and enters active power-down instead.
- R10: Exit from power-down happens on the first edge at which `cke` is high. `pwr_state` returns to 0 and the command sampled at that edge is ignored.
- R11: Exit from self refresh does not wait for a clock edge. `pwr_state` reads 0 as soon as `cke` is high, and the command sampled at the next edge is executed.
- R12: While in a power-down or self-refresh state with `cke` low, every sampled command is ignored.
- R13: If `cke` is low at an edge while `busy` is high, `cke_viol` pulses for one cycle. The block stays in the active state and the command is ignored.
- R14: While reset is asserted, all banks are idle, both mode registers are 0, `pwr_state` is 0, and `busy`, `err_illegal` and `cke_viol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write enable command bit |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Row, column or mode value; bit 10 selects all-bank or auto-precharge |
| bank_open | output | NUM_BANKS | One bit per bank, set while a row is open |
| open_row | output | NUM_BANKS*ADDR_W | Latched row of each bank |
| mode_reg | output | ADDR_W | Mode register |
| ext_mode_reg | output | ADDR_W | Extended mode register |
| pwr_state | output | 2 | 0 active, 1 precharge power-down, 2 active power-down, 3 self refresh |
| busy | output | 1 | Read or write burst in progress |
| err_illegal | output | 1 | One-cycle pulse on an illegal command |
| cke_viol | output | 1 | One-cycle pulse when clock enable drops during a burst |

## Verification
The bench builds the block with its defaults: four banks, a 12-bit address and a burst window of four cycles. A four-cycle window leaves room to put a second Read inside a pending auto-precharge and to stop a burst early, both before the deferred close fires. Four banks are enough to tell a single-bank precharge apart from an all-bank precharge. The self-refresh exit is sampled between clock edges, which shows that the state changes before the next edge arrives.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ACT = 2'd0,
    PWR_PPD = 2'd1,
    PWR_APD = 2'd2,
    PWR_SR  = 2'd3
  } pwr_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  // A deselected device sees no operation.
  always_comb begin
    if (cs_n) cmd = CMD_NOP;
    else      cmd = cmd_e'({ras_n, cas_n, we_n});
  end
endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int BA_W      = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_en,
  input  logic [BA_W-1:0]            act_bank,
  input  logic [ROW_W-1:0]           act_row,
  input  logic [NUM_BANKS-1:0]       close_mask,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_row
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic [BA_W-1:0] IDX = BA_W'(g);
    logic             open_q, open_d;
    logic             row_we;
    logic [ROW_W-1:0] row_q;

    always_comb begin
      row_we = 1'b0;
      open_d = open_q;
      if (close_mask[g]) begin
        open_d = 1'b0;
      end else if (act_en && (act_bank == IDX)) begin
        open_d = 1'b1;
        row_we = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else begin
        open_q <= open_d;
        if (row_we) row_q <= act_row;
      end
    end

    assign bank_open[g]               = open_q;
    assign open_row[g*ROW_W +: ROW_W] = row_q;
  end
endmodule

// File: rtl/sdram_pwr_ctl.sv
module sdram_pwr_ctl
  import sdram_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic sr_req,
  input  logic any_open,
  input  logic busy,
  output pwr_e pwr_state,
  output logic accept,
  output logic viol,
  output logic sr_refused
);
  pwr_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    viol       = 1'b0;
    sr_refused = 1'b0;
    case (st_q)
      PWR_ACT: begin
        if (!cke) begin
          if (busy) begin
            viol = 1'b1;
          end else if (sr_req) begin
            if (any_open) begin
              sr_refused = 1'b1;
              st_d       = PWR_APD;
            end else begin
              st_d = PWR_SR;
            end
          end else begin
            st_d = any_open ? PWR_APD : PWR_PPD;
          end
        end
      end
      PWR_PPD, PWR_APD: if (cke) st_d = PWR_ACT;
      PWR_SR:           if (cke) st_d = PWR_ACT;
      default:          st_d = PWR_ACT;
    endcase
  end

  // Self-refresh exit is combinational on cke; power-down exit waits an edge.
  assign accept    = cke && ((st_q == PWR_ACT) || (st_q == PWR_SR));
  assign pwr_state = ((st_q == PWR_SR) && cke) ? PWR_ACT : st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PWR_ACT;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int BURST_CYC = 4,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cke,
  input  logic                        cs_n,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic                        we_n,
  input  logic [BA_W-1:0]             ba,
  input  logic [ADDR_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]        bank_open,
  output logic [NUM_BANKS*ADDR_W-1:0] open_row,
  output logic [ADDR_W-1:0]           mode_reg,
  output logic [ADDR_W-1:0]           ext_mode_reg,
  output logic [1:0]                  pwr_state,
  output logic                        busy,
  output logic                        err_illegal,
  output logic                        cke_viol
);
  localparam int CNT_W = $clog2(BURST_CYC + 1);

  cmd_e                 cmd;
  pwr_e                 pwr_w;
  logic                 accept, viol, sr_refused;
  logic                 any_open, sel_open;
  logic [NUM_BANKS-1:0] sel_mask, ap_mask, close_mask;
  logic                 act_en, mr_we, emr_we, illegal, ap_fire;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 ap_pend_q, ap_pend_d;
  logic [BA_W-1:0]      ap_bank_q, ap_bank_d;
  logic [ADDR_W-1:0]    mode_q, emode_q;
  logic                 err_q, viol_q;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  sdram_pwr_ctl u_pwr (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .sr_req(cmd == CMD_REF), .any_open(any_open), .busy(busy),
    .pwr_state(pwr_w), .accept(accept), .viol(viol), .sr_refused(sr_refused)
  );

  sdram_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ADDR_W), .BA_W(BA_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .act_bank(ba), .act_row(addr),
    .close_mask(close_mask), .bank_open(bank_open), .open_row(open_row)
  );

  assign any_open = |bank_open;
  assign sel_open = bank_open[ba];
  assign sel_mask = NUM_BANKS'(1) << ba;
  assign ap_mask  = NUM_BANKS'(1) << ap_bank_q;
  assign busy     = (cnt_q != '0);
  assign ap_fire  = ap_pend_q && (cnt_q == CNT_W'(1));

  always_comb begin
    act_en     = 1'b0;
    mr_we      = 1'b0;
    emr_we     = 1'b0;
    illegal    = sr_refused;
    close_mask = '0;
    cnt_d      = busy ? cnt_q - CNT_W'(1) : '0;
    ap_pend_d  = ap_pend_q;
    ap_bank_d  = ap_bank_q;
    if (ap_fire) begin
      close_mask = ap_mask;
      ap_pend_d  = 1'b0;
    end
    if (accept) begin
      case (cmd)
        CMD_ACT: begin
          if (sel_open) illegal = 1'b1;
          else          act_en  = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          if (!sel_open || ap_pend_q) begin
            illegal = 1'b1;
          end else begin
            cnt_d = CNT_W'(BURST_CYC);
            if (addr[AP_BIT]) begin
              ap_pend_d = 1'b1;
              ap_bank_d = ba;
            end
          end
        end
        CMD_PRE: begin
          close_mask = close_mask | (addr[AP_BIT] ? {NUM_BANKS{1'b1}} : sel_mask);
          if (ap_pend_q && close_mask[ap_bank_q]) ap_pend_d = 1'b0;
        end
        CMD_BST: begin
          cnt_d = '0;
          if (ap_pend_q) begin
            close_mask = close_mask | ap_mask;
            ap_pend_d  = 1'b0;
          end
        end
        CMD_REF: if (any_open) illegal = 1'b1;
        CMD_MRS: begin
          if (any_open || (ba > BA_W'(1))) illegal = 1'b1;
          else if (ba == '0)               mr_we   = 1'b1;
          else                             emr_we  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ap_pend_q <= 1'b0;
      ap_bank_q <= '0;
      mode_q    <= '0;
      emode_q   <= '0;
      err_q     <= 1'b0;
      viol_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      ap_pend_q <= ap_pend_d;
      ap_bank_q <= ap_bank_d;
      if (mr_we)  mode_q  <= addr;
      if (emr_we) emode_q <= addr;
      err_q     <= illegal;
      viol_q    <= viol;
    end
  end

  assign mode_reg     = mode_q;
  assign ext_mode_reg = emode_q;
  assign pwr_state    = pwr_w;
  assign err_illegal  = err_q;
  assign cke_viol     = viol_q;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cke,
  input logic                        cs_n,
  input logic [NUM_BANKS-1:0]        bank_open,
  input logic [NUM_BANKS*ADDR_W-1:0] open_row,
  input logic [ADDR_W-1:0]           mode_reg,
  input logic [ADDR_W-1:0]           ext_mode_reg,
  input logic [1:0]                  pwr_state,
  input logic                        busy,
  input logic                        err_illegal,
  input logic                        cke_viol
);
  // R1: deselected cycle with no burst leaves banks alone and raises nothing
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cke && pwr_state == 2'd0 && !busy) |=> ($stable(bank_open) && !err_illegal));

  // R12: low-power states with cke low freeze all tracked state
  a_r12_lowpower_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 2'd1 || pwr_state == 2'd2) && !cke)
      |=> ($stable(bank_open) && $stable(open_row) && $stable(mode_reg) && $stable(ext_mode_reg)));

  // R8: precharge power-down only with every bank idle
  a_r8_ppd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1) |-> (bank_open == '0));

  // R8: active power-down only with a row open
  a_r8_apd_open: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2) |-> (bank_open != '0));

  // R9: self refresh only with every bank idle
  a_r9_sr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd3) |-> (bank_open == '0));

  // R13: cke dropped mid-burst is flagged and the device stays active
  a_r13_cke_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && !cke && busy) |=> (cke_viol && pwr_state == 2'd0));

  // R3: an illegal-command pulse and a clock-enable violation never coincide
  a_r3_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_illegal && cke_viol));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
  .bank_open(bank_open), .open_row(open_row),
  .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg),
  .pwr_state(pwr_state), .busy(busy),
  .err_illegal(err_illegal), .cke_viol(cke_viol)
);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;
  localparam int CLK_P = 10;
  localparam logic [2:0] OP_MRS = 3'b000, OP_REF = 3'b001, OP_PRE = 3'b010,
                         OP_ACT = 3'b011, OP_WR  = 3'b100, OP_RD  = 3'b101,
                         OP_BST = 3'b110, OP_NOP = 3'b111;
  localparam logic [11:0] AP = 12'h400;

  logic        clk, rst_n, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [3:0]  bank_open;
  logic [47:0] open_row;
  logic [11:0] mode_reg, ext_mode_reg;
  logic [1:0]  pwr_state;
  logic        busy, err_illegal, cke_viol;
  int          n_chk = 0;
  int          n_err = 0;

  sdram_cmd_tracker u_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .bank_open(bank_open), .open_row(open_row), .mode_reg(mode_reg),
    .ext_mode_reg(ext_mode_reg), .pwr_state(pwr_state), .busy(busy),
    .err_illegal(err_illegal), .cke_viol(cke_viol)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic c, input logic [2:0] op,
                      input logic [1:0] b, input logic [11:0] a);
    @(negedge clk);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = op; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic nop(input logic k);
    step(k, 1'b0, OP_NOP, 2'd0, 12'h000);
  endtask

  task automatic t_reset;
    check("R14 bank_open", 32'(bank_open), 0);
    check("R14 mode regs", 32'({mode_reg, ext_mode_reg}), 0);
    check("R14 pwr/busy/err", 32'({pwr_state, busy, err_illegal, cke_viol}), 0);
  endtask

  task automatic t_activate;
    step(1, 0, OP_ACT, 2'd2, 12'hABC);
    check("R2 act opens bank2", 32'(bank_open), 32'h4);
    check("R2 row latched", 32'(open_row[2*12 +: 12]), 32'hABC);
    step(1, 0, OP_ACT, 2'd2, 12'h123);
    check("R3 act on open bank err", 32'(err_illegal), 1);
    check("R3 row kept", 32'(open_row[2*12 +: 12]), 32'hABC);
    nop(1);
    check("R3 err is a pulse", 32'(err_illegal), 0);
    step(1, 1, OP_ACT, 2'd1, 12'h055);
    check("R1 deselected act ignored", 32'(bank_open), 32'h4);
    check("R1 no err when deselected", 32'(err_illegal), 0);
  endtask

  task automatic t_read_write;
    step(1, 0, OP_RD, 2'd0, 12'h010);
    check("R3 read idle bank err", 32'(err_illegal), 1);
    check("R3 read idle no busy", 32'(busy), 0);
    step(1, 0, OP_RD, 2'd2, 12'h010);
    check("R5 busy after read", 32'(busy), 1);
    nop(1); nop(1); nop(1);
    check("R5 busy through window", 32'(busy), 1);
    nop(1);
    check("R5 busy ends", 32'(busy), 0);
    check("R5 plain read keeps bank", 32'(bank_open), 32'h4);
    step(1, 0, OP_WR, 2'd2, AP | 12'h020);
    step(1, 0, OP_RD, 2'd2, 12'h020);
    check("R5 read during pending close err", 32'(err_illegal), 1);
    nop(1); nop(1);
    check("R5 bank open before close", 32'(bank_open), 32'h4);
    nop(1);
    check("R5 auto close at window end", 32'(bank_open), 32'h0);
    check("R5 busy off with close", 32'(busy), 0);
    step(1, 0, OP_ACT, 2'd0, 12'h001);
    step(1, 0, OP_RD, 2'd0, AP);
    step(1, 0, OP_BST, 2'd0, 12'h000);
    check("R5 stop clears busy", 32'(busy), 0);
    check("R5 stop completes close", 32'(bank_open), 32'h0);
  endtask

  task automatic t_precharge;
    step(1, 0, OP_ACT, 2'd0, 12'h100);
    step(1, 0, OP_ACT, 2'd1, 12'h101);
    step(1, 0, OP_ACT, 2'd3, 12'h103);
    step(1, 0, OP_PRE, 2'd1, 12'h000);
    check("R4 single bank precharge", 32'(bank_open), 32'h9);
    step(1, 0, OP_PRE, 2'd1, AP);
    check("R4 all bank precharge", 32'(bank_open), 32'h0);
  endtask

  task automatic t_mode_set;
    step(1, 0, OP_MRS, 2'd0, 12'h033);
    check("R6 mode reg written", 32'(mode_reg), 32'h033);
    step(1, 0, OP_MRS, 2'd1, 12'h002);
    check("R6 ext mode written", 32'(ext_mode_reg), 32'h002);
    check("R6 mode reg untouched", 32'(mode_reg), 32'h033);
    step(1, 0, OP_MRS, 2'd2, 12'h7FF);
    check("R6 bad bank select err", 32'(err_illegal), 1);
    check("R6 no write on bad select", 32'({mode_reg, ext_mode_reg}), 32'h033002);
    step(1, 0, OP_ACT, 2'd0, 12'h000);
    step(1, 0, OP_MRS, 2'd0, 12'h111);
    check("R6 mode set with open bank err", 32'(err_illegal), 1);
    check("R6 mode kept", 32'(mode_reg), 32'h033);
  endtask

  task automatic t_refresh;
    step(1, 0, OP_REF, 2'd0, 12'h000);
    check("R7 refresh with open bank err", 32'(err_illegal), 1);
    step(1, 0, OP_PRE, 2'd0, AP);
    step(1, 0, OP_REF, 2'd0, 12'h000);
    check("R7 refresh idle ok", 32'(err_illegal), 0);
    check("R7 refresh no state change", 32'({bank_open, pwr_state}), 0);
  endtask

  task automatic t_powerdown;
    nop(0);
    check("R8 idle cke low -> ppd", 32'(pwr_state), 1);
    step(0, 0, OP_ACT, 2'd0, 12'h000);
    check("R12 act ignored in ppd", 32'(bank_open), 0);
    step(1, 0, OP_ACT, 2'd0, 12'h000);
    check("R10 exit to active", 32'(pwr_state), 0);
    check("R10 exit-edge cmd ignored", 32'(bank_open), 0);
    step(1, 0, OP_ACT, 2'd0, 12'h000);
    check("R10 cmd after exit runs", 32'(bank_open), 1);
    step(0, 0, OP_PRE, 2'd0, AP);
    check("R8 open bank cke low -> apd", 32'(pwr_state), 2);
    check("R8 entry-edge cmd ignored", 32'(bank_open), 1);
    nop(1);
    check("R10 apd exit", 32'(pwr_state), 0);
    step(1, 0, OP_PRE, 2'd0, AP);
  endtask

  task automatic t_self_refresh;
    step(0, 0, OP_REF, 2'd0, 12'h000);
    check("R9 self refresh entry", 32'(pwr_state), 3);
    step(0, 0, OP_ACT, 2'd2, 12'h000);
    check("R12 act ignored in sr", 32'({bank_open, pwr_state}), 3);
    @(negedge clk);
    cke = 1; cs_n = 0; {ras_n, cas_n, we_n} = OP_ACT; ba = 2'd3; addr = 12'h0EE;
    #1;
    check("R11 async sr exit", 32'(pwr_state), 0);
    @(posedge clk);
    #1;
    check("R11 next-edge cmd runs", 32'(bank_open), 32'h8);
    step(0, 0, OP_REF, 2'd0, 12'h000);
    check("R9 sr refused with open bank", 32'(err_illegal), 1);
    check("R9 refused goes apd", 32'(pwr_state), 2);
    nop(1);
    step(1, 0, OP_PRE, 2'd0, AP);
  endtask

  task automatic t_cke_violation;
    step(1, 0, OP_ACT, 2'd0, 12'h000);
    step(1, 0, OP_RD, 2'd0, 12'h000);
    step(0, 0, OP_PRE, 2'd0, AP);
    check("R13 cke drop flagged", 32'(cke_viol), 1);
    check("R13 stays active", 32'(pwr_state), 0);
    check("R13 cmd ignored", 32'(bank_open), 1);
    nop(1);
    check("R13 flag is a pulse", 32'(cke_viol), 0);
    nop(1); nop(1);
    step(1, 0, OP_PRE, 2'd0, AP);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; cke = 1; cs_n = 1; {ras_n, cas_n, we_n} = OP_NOP; ba = 0; addr = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1;
    nop(1);
    t_reset();
    t_activate();
    t_read_write();
    t_precharge();
    t_mode_set();
    t_refresh();
    t_powerdown();
    t_self_refresh();
    t_cke_violation();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule